// File: doc/BRIEF.md
# Patterned-Rate Stream Consumer

This block pulls values from an upstream valid/ready port on a fixed schedule. A mode input selects the schedule. The steady schedule takes one value at a regular interval. The burst schedule waits through a long idle stretch and then takes a run of values on consecutive cycles. With the default parameters, both schedules take one value per three cycles on average. This lets an upstream buffer or clock-crossing FIFO be tested under an even load and under a bursty load of the same average rate.

Each accepted value is folded into a running XOR checksum and counted. A testbench can compare both against the values it sent. If a scheduled take finds no valid data, the schedule waits with ready held high until data arrives, so no take is lost. The mode is captured only while reset is applied, and every schedule starts at its first cycle when reset is released.

Top module: `pattern_consumer`

## Requirements
- R1: While rst_n is low (sampled at a clock edge), src_ready_o is 0 and take_count_o and checksum_o are 0 from the following edge onward.
- R2: Steady mode (mode input 0) with src_valid_i held high: counting the first cycle after reset release as cycle 0, src_ready_o is high in cycles 2, 5, 8, … and low in every other cycle.
- R3: Burst mode (mode input 1) with src_valid_i held high: src_ready_o is low in cycles 0–19, high in cycles 20–29, and this 30-cycle pattern repeats without end.
- R4: The mode input is captured only while rst_n is low; changing it after reset release has no effect on the schedule.
- R5: If src_ready_o is high and src_valid_i is low, src_ready_o stays high and the schedule does not advance until a transfer takes place, so a missed take is delayed, never dropped.
- R6: take_count_o increases by exactly one in the cycle after each transfer (src_ready_o and src_valid_i both high) and holds its value otherwise.
- R7: checksum_o becomes the XOR of all data accepted in transfers, one cycle after each transfer; data presented while src_ready_o is low has no effect.
- R8: With src_valid_i always high, both modes accept exactly 100 values in the first 300 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| burst_mode_i | input | 1 | Schedule select: 0 steady, 1 burst |
| src_valid_i | input | 1 | Upstream has a value available |
| src_data_i | input | DATA_W | Upstream value |
| src_ready_o | output | 1 | Block takes a value this cycle if src_valid_i is high |
| take_count_o | output | CNT_W | Number of values accepted since reset |
| checksum_o | output | DATA_W | XOR of all values accepted since reset |

## Verification
Two functions can fall in the same cycle: a scheduled take and a missing upstream value. When they collide, the stall logic must hold ready high and freeze the schedule, and the accumulator must not count the cycle. The bench provokes this with random valid rates below 100% in both modes. It also holds valid low over the start of a burst run, so the whole run slips. It judges each cycle against its own schedule model, which slips only on such cycles. In those cycles any mismatch is reported as a stall error.

// File: rtl/pc_pkg.sv
// Package: shared types and helpers for the patterned-rate consumer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package pc_pkg;

    typedef enum logic {
        SCHED_STEADY = 1'b0,
        SCHED_BURST  = 1'b1
    } sched_mode_e;

    // Width needed to hold values 0..n-1, at least one bit.
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pc_sched_steady.sv
// Module: steady schedule. It requests one take every GAP cycles.
// Assumes GAP >= 1. While the block is inactive, its phase stays at zero.
// A requested take that finds no valid data freezes the phase.
module pc_sched_steady
    import pc_pkg::*;
#(
    parameter int unsigned GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic src_valid,
    output logic want
);
    localparam int unsigned PW   = idx_width(GAP);
    localparam logic [PW-1:0] LAST = PW'(GAP - 1);

    logic [PW-1:0] ph_q;
    logic          advance;

    // Purpose: request a take in the last slot of each period.
    always_comb begin
        want    = active && (ph_q == LAST);
        advance = active && !(want && !src_valid);
    end

    // Purpose: step the phase, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (advance) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end
    end

    // R5: an unserved request persists.
    a_r5_steady_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !src_valid) |=> want);

    generate
        if (GAP >= 3) begin : g_gap_chk
            // R2: after a take, the next two cycles make no request.
            a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (want && src_valid) |=> (!want ##1 !want));
        end
    endgenerate
endmodule

// File: rtl/pc_sched_burst.sv
// Module: burst schedule. It idles for IDLE cycles, then requests RUN takes
// on consecutive cycles, and repeats. Assumes IDLE >= 1 and RUN >= 1. While
// the block is inactive, its phase stays at zero. An unserved request
// freezes the phase.
module pc_sched_burst
    import pc_pkg::*;
#(
    parameter int unsigned IDLE = 20,
    parameter int unsigned RUN  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic src_valid,
    output logic want
);
    localparam int unsigned PER  = IDLE + RUN;
    localparam int unsigned PW   = idx_width(PER);
    localparam logic [PW-1:0] LAST  = PW'(PER - 1);
    localparam logic [PW-1:0] START = PW'(IDLE);

    logic [PW-1:0] ph_q;
    logic          advance;

    // Purpose: request takes during the run part of the period.
    always_comb begin
        want    = active && (ph_q >= START);
        advance = active && !(want && !src_valid);
    end

    // Purpose: step the phase through idle and run, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (advance) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end
    end

    // R3: the last take of a run is followed by an idle cycle.
    a_r3_run_end: assert property (@(posedge clk) disable iff (!rst_n)
        (want && src_valid && ph_q == LAST) |=> !want);

    // R5: an unserved request persists.
    a_r5_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !src_valid) |=> want);
endmodule

// File: rtl/pc_accum.sv
// Module: transfer counter and XOR checksum. Updates one cycle after each
// accepted transfer. Assumes fire is already qualified by ready and valid.
module pc_accum #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] checksum
);
    // Purpose: fold each accepted value into the count and the checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            checksum <= '0;
        end else if (fire) begin
            count    <= count + 1'b1;
            checksum <= checksum ^ data;
        end
    end

    // R6: one step per transfer.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (count == $past(count) + 1'b1));

    // R7: no transfer leaves both results unchanged.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(count) && $stable(checksum)));
endmodule

// File: rtl/pattern_consumer.sv
// Module: patterned-rate stream consumer (top). It captures the mode while
// reset is low, runs the selected schedule and accumulates accepted data.
// Assumes the upstream port follows valid/ready rules: a transfer happens
// in any cycle in which both are high.
module pattern_consumer
    import pc_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned STEADY_GAP = 3,
    parameter int unsigned BURST_IDLE = 20,
    parameter int unsigned BURST_RUN  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_mode_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    output logic [CNT_W-1:0]  take_count_o,
    output logic [DATA_W-1:0] checksum_o
);
    sched_mode_e mode_q;
    logic        steady_on;
    logic        burst_on;
    logic        want_steady;
    logic        want_burst;
    logic        fire;

    // Purpose: capture the mode only while reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= sched_mode_e'(burst_mode_i);
        end
    end

    // Purpose: enable one schedule and form the handshake.
    always_comb begin
        steady_on   = (mode_q == SCHED_STEADY);
        burst_on    = (mode_q == SCHED_BURST);
        src_ready_o = want_steady | want_burst;
        fire        = src_ready_o & src_valid_i;
    end

    pc_sched_steady #(
        .GAP (STEADY_GAP)
    ) u_steady (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (steady_on),
        .src_valid (src_valid_i),
        .want      (want_steady)
    );

    pc_sched_burst #(
        .IDLE (BURST_IDLE),
        .RUN  (BURST_RUN)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (burst_on),
        .src_valid (src_valid_i),
        .want      (want_burst)
    );

    pc_accum #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .data     (src_data_i),
        .count    (take_count_o),
        .checksum (checksum_o)
    );

    // R4: the captured mode never changes outside reset.
    a_r4_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) || $stable(mode_q)));

    // R2, R3: exactly one schedule may request at a time.
    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_steady && want_burst));
endmodule

// File: tb/tb_pattern_consumer.sv
`timescale 1ns/1ps
module tb_pattern_consumer;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst_mode = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          ready;
    logic [CW-1:0] cnt;
    logic [DW-1:0] csum;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int cyc = 0;

    int            m_mode;
    int            m_ph;
    bit            m_stalled;
    logic [CW-1:0] m_cnt;
    logic [DW-1:0] m_csum;

    pattern_consumer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode_i (burst_mode),
        .src_valid_i  (src_valid),
        .src_data_i   (src_data),
        .src_ready_o  (ready),
        .take_count_o (cnt),
        .checksum_o   (csum)
    );

    always #2.5 clk = ~clk;

    // Expected request from the schedule definitions (R2, R3).
    function automatic bit exp_want(int mode, int ph);
        return (mode != 0) ? (ph >= 20) : (ph == 2);
    endfunction

    // Expected next phase, frozen on an unserved request (R5).
    function automatic int next_ph(int mode, int ph, bit valid);
        if (exp_want(mode, ph) && !valid) return ph;
        return (mode != 0) ? ((ph + 1) % 30) : ((ph + 1) % 3);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset(bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        burst_mode = mode;
        src_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ready", 32'(ready), 32'd0);
        check("R1 count", 32'(cnt), 32'd0);
        check("R1 checksum", 32'(csum), 32'd0);
        rst_n = 1'b1;
        m_mode = mode;
        m_ph = 0;
        m_stalled = 0;
        m_cnt = '0;
        m_csum = '0;
    endtask

    // One cycle per iteration: check outputs, drive new inputs, update the model.
    task automatic run(int n, int vpct, bit flip);
        for (int i = 0; i < n; i++) begin
            bit v;
            bit w;
            string tag;
            w = exp_want(m_mode, m_ph);
            if (flip) tag = "R4 ready";
            else if (m_stalled) tag = "R5 ready";
            else if (m_mode != 0) tag = "R3 ready";
            else tag = "R2 ready";
            check(tag, 32'(ready), 32'(w));
            check("R6 count", 32'(cnt), 32'(m_cnt));
            check("R7 checksum", 32'(csum), 32'(m_csum));
            v = (($urandom % 100) < vpct);
            src_valid = v;
            src_data = DW'($urandom);
            if (flip && ($urandom % 4 == 0)) burst_mode = ~burst_mode;
            if (w && v) begin
                m_cnt = m_cnt + 1'b1;
                m_csum = m_csum ^ src_data;
            end
            m_stalled = w && !v;
            m_ph = next_ph(m_mode, m_ph, v);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // Steady with valid always high: count after 300 cycles (R8).
        do_reset(1'b0);
        run(300, 100, 1'b0);
        check("R8 steady total", 32'(cnt), 32'd100);
        // Burst with valid always high (R3, R8).
        do_reset(1'b1);
        run(300, 100, 1'b0);
        check("R8 burst total", 32'(cnt), 32'd100);
        // Random valid in steady mode: stalls collide with takes (R5).
        do_reset(1'b0);
        run(400, 60, 1'b0);
        // Burst: valid held low over the start of a run, then random (R5).
        do_reset(1'b1);
        run(25, 0, 1'b0);
        run(400, 70, 1'b0);
        // Mode input toggled after reset must be ignored (R4).
        do_reset(1'b0);
        run(300, 80, 1'b1);
        do_reset(1'b1);
        run(300, 80, 1'b1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule